// File: doc/BRIEF.md
# Run-Length Control-Flow Trace Buffer

This block keeps a running history of a controller's state register in a circular on-chip memory. Most controller transitions advance the state by exactly one, so the block does not store one line per cycle. Instead, each stored entry holds the state that opened a run and a count of how many sequential steps followed it. A fresh entry starts only in three cases: the progression breaks (a branch, call, return or held state), the run counter is full, or the recorder is halted.

While capture is enabled, recording runs every clock cycle. Once the memory is full, new entries overwrite the oldest ones. When the halt input fires, the block writes the partly built entry, freezes, and serves reads through a port that is indexed from the oldest surviving entry. The block also exports the current write index and run count at all times. A companion data-trace recorder can use that pair to stamp each of its records with a position in the control history.

Top module: `ctrl_trace_rle`

## Requirements
- R1: After reset, `wr_idx_o`, `seq_cnt_o` and `entries_o` are zero, and `wrapped_o` and `halted_o` are low.
- R2: A captured state equal to the previously captured state plus one (modulo 2^STATE_W) extends the open entry. `seq_cnt_o` rises by one and `wr_idx_o` is unchanged.
- R3: A captured state that is not the previous state plus one closes the open entry. This includes a repeat of the same state. The entry (opening state, run count) is written at `wr_idx_o`, `wr_idx_o` advances by one, and a new entry opens with the new state and count zero.
- R4: When the run count is 2^SEQ_W-1, the next sequential state closes the entry and opens a new one with count zero. An entry therefore spans at most 2^SEQ_W cycles.
- R5: While `capture_en_i` is low, `state_i` is ignored. `wr_idx_o` and `seq_cnt_o` hold, and the next captured state is compared with the last captured one.
- R6: A cycle with `halt_i` high writes the open entry, if there is one, and sets `halted_o` one cycle later. After that, `halted_o` stays high until reset and no further state is recorded.
- R7: `rd_state_o` and `rd_seq_o` show, one cycle after `rd_idx_i` is presented, the entry at position `rd_idx_i` counted from the oldest surviving entry (0 = oldest).
- R8: After DEPTH entries have been written, `wrapped_o` is high and stays high. Later entries overwrite the oldest ones, and read position 0 maps to the entry at `wr_idx_o`.
- R9: `entries_o` equals `wr_idx_o` before the first wrap and DEPTH after it.
- R10: A step from the all-ones state to state zero counts as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_en_i | input | 1 | Sample `state_i` this cycle |
| state_i | input | STATE_W | Controller state value |
| halt_i | input | 1 | Stop recording and write the open entry |
| rd_idx_i | input | AW | Read position relative to the oldest entry |
| rd_state_o | output | STATE_W | Opening state of the entry that was read |
| rd_seq_o | output | SEQ_W | Run count of the entry that was read |
| wr_idx_o | output | AW | Slot that the open entry will occupy |
| seq_cnt_o | output | SEQ_W | Run count of the open entry |
| wrapped_o | output | 1 | Oldest data has been overwritten |
| halted_o | output | 1 | Recording has stopped |
| entries_o | output | AW+1 | Number of valid entries |

## Verification
The stimulus mixes several kinds of state sequence:
- Short sequential runs, which exercise extension of the open entry.
- Held states and far jumps, which separate a real break from an accidental match.
- The step from all-ones to zero, which shows whether the increment is modular.
- A long unbroken count, which shows whether saturation closes the entry at exactly 2^SEQ_W cycles.
- Gaps with capture disabled, in which junk states on the input must leave the run intact.
- A stream of many non-sequential states longer than the memory depth, which separates correct oldest-first readout after a wrap from readout that starts at slot zero.

Every entry the scoreboard expects is compared against the drained memory after halt.

// File: rtl/ctrl_trace_pkg.sv
package ctrl_trace_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_EXTEND,
    ACT_START,
    ACT_ROLL,
    ACT_FLUSH
  } trk_act_e;
endpackage

// File: rtl/ctrl_run_tracker.sv
module ctrl_run_tracker
  import ctrl_trace_pkg::*;
#(
  parameter int STATE_W = 12,
  parameter int SEQ_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               halt_i,
  output logic               commit_o,
  output logic [STATE_W-1:0] commit_state_o,
  output logic [SEQ_W-1:0]   commit_seq_o,
  output logic [SEQ_W-1:0]   seq_o,
  output logic               halted_o
);
  localparam logic [SEQ_W-1:0] SEQ_MAX = '1;

  logic               open_q, halted_q;
  logic [STATE_W-1:0] start_q, last_q;
  logic [SEQ_W-1:0]   seq_q;
  logic               is_next;
  trk_act_e           act_d;

  assign is_next = (state_i == STATE_W'(last_q + 1'b1));

  always_comb begin
    act_d = ACT_IDLE;
    if (halted_q)                           act_d = ACT_IDLE;
    else if (halt_i)                        act_d = ACT_FLUSH;
    else if (!cap_i)                        act_d = ACT_IDLE;
    else if (!open_q)                       act_d = ACT_START;
    else if (is_next && seq_q != SEQ_MAX)   act_d = ACT_EXTEND;
    else                                    act_d = ACT_ROLL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= 1'b0;
      halted_q <= 1'b0;
      start_q  <= '0;
      last_q   <= '0;
      seq_q    <= '0;
    end else begin
      unique case (act_d)
        ACT_EXTEND: begin
          last_q <= state_i;
          seq_q  <= seq_q + 1'b1;
        end
        ACT_START, ACT_ROLL: begin
          open_q  <= 1'b1;
          start_q <= state_i;
          last_q  <= state_i;
          seq_q   <= '0;
        end
        ACT_FLUSH: begin
          open_q   <= 1'b0;
          halted_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign commit_o       = open_q && (act_d == ACT_ROLL || act_d == ACT_FLUSH);
  assign commit_state_o = start_q;
  assign commit_seq_o   = seq_q;
  assign seq_o          = seq_q;
  assign halted_o       = halted_q;
endmodule

// File: rtl/ctrl_trace_ring.sv
module ctrl_trace_ring #(
  parameter int ENTRY_W = 18,
  parameter int DEPTH   = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic [AW-1:0]      wr_ptr_o,
  output logic               wrapped_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]      ptr_q;
  logic               wrap_q;
  logic [ENTRY_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (wr_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (ptr_q == LAST) wrap_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
  assign wr_ptr_o  = ptr_q;
  assign wrapped_o = wrap_q;
endmodule

// File: rtl/ctrl_trace_reader.sv
module ctrl_trace_reader #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] rd_idx_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic          wrapped_i,
  output logic [AW-1:0] phys_o,
  output logic [AW:0]   count_o
);
  // oldest entry sits at the write pointer once the ring has wrapped
  assign phys_o  = wrapped_i ? AW'(wr_ptr_i + rd_idx_i) : rd_idx_i;
  assign count_o = wrapped_i ? (AW+1)'(DEPTH) : {1'b0, wr_ptr_i};
endmodule

// File: rtl/ctrl_trace_rle.sv
module ctrl_trace_rle #(
  parameter int STATE_W = 12,
  parameter int SEQ_W   = 6,
  parameter int DEPTH   = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_en_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               halt_i,
  input  logic [AW-1:0]      rd_idx_i,
  output logic [STATE_W-1:0] rd_state_o,
  output logic [SEQ_W-1:0]   rd_seq_o,
  output logic [AW-1:0]      wr_idx_o,
  output logic [SEQ_W-1:0]   seq_cnt_o,
  output logic               wrapped_o,
  output logic               halted_o,
  output logic [AW:0]        entries_o
);
  localparam int ENTRY_W = STATE_W + SEQ_W;

  logic               commit;
  logic [STATE_W-1:0] commit_state;
  logic [SEQ_W-1:0]   commit_seq;
  logic [AW-1:0]      wr_ptr, rd_phys;
  logic               wrapped;
  logic [ENTRY_W-1:0] rd_data;

  ctrl_run_tracker #(.STATE_W(STATE_W), .SEQ_W(SEQ_W)) u_trk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cap_i          (capture_en_i),
    .state_i        (state_i),
    .halt_i         (halt_i),
    .commit_o       (commit),
    .commit_state_o (commit_state),
    .commit_seq_o   (commit_seq),
    .seq_o          (seq_cnt_o),
    .halted_o       (halted_o)
  );

  ctrl_trace_ring #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (commit),
    .wr_data_i ({commit_state, commit_seq}),
    .rd_addr_i (rd_phys),
    .rd_data_o (rd_data),
    .wr_ptr_o  (wr_ptr),
    .wrapped_o (wrapped)
  );

  ctrl_trace_reader #(.DEPTH(DEPTH)) u_rd (
    .rd_idx_i  (rd_idx_i),
    .wr_ptr_i  (wr_ptr),
    .wrapped_i (wrapped),
    .phys_o    (rd_phys),
    .count_o   (entries_o)
  );

  assign rd_state_o = rd_data[ENTRY_W-1:SEQ_W];
  assign rd_seq_o   = rd_data[SEQ_W-1:0];
  assign wr_idx_o   = wr_ptr;
  assign wrapped_o  = wrapped;
endmodule

// File: rtl/ctrl_trace_rle_chk.sv
module ctrl_trace_rle_chk #(
  parameter int STATE_W = 12,
  parameter int SEQ_W   = 6,
  parameter int DEPTH   = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               capture_en_i,
  input logic               halt_i,
  input logic [AW-1:0]      wr_idx_o,
  input logic [SEQ_W-1:0]   seq_cnt_o,
  input logic               wrapped_o,
  input logic               halted_o,
  input logic [AW:0]        entries_o
);
  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (wr_idx_o == $past(wr_idx_o) || wr_idx_o == AW'($past(wr_idx_o) + 1'b1)));

  p_new_entry_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !$past(halted_o) && wr_idx_o != $past(wr_idx_o)) |-> seq_cnt_o == '0);

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_en_i && !halt_i && !halted_o) |=> ($stable(wr_idx_o) && $stable(seq_cnt_o)));

  p_halt_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  p_halt_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(wr_idx_o) && $stable(wrapped_o)));

  p_wrap_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_o |=> wrapped_o);

  p_count_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_o |-> entries_o == (AW+1)'(DEPTH));

  p_count_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrapped_o |-> entries_o == {1'b0, wr_idx_o});
endmodule

bind ctrl_trace_rle ctrl_trace_rle_chk #(
  .STATE_W(STATE_W), .SEQ_W(SEQ_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .capture_en_i (capture_en_i),
  .halt_i       (halt_i),
  .wr_idx_o     (wr_idx_o),
  .seq_cnt_o    (seq_cnt_o),
  .wrapped_o    (wrapped_o),
  .halted_o     (halted_o),
  .entries_o    (entries_o)
);

// File: tb/ctrl_trace_rle_tb.sv
`timescale 1ns/1ps
module ctrl_trace_rle_tb;
  localparam int STATE_W = 12;
  localparam int SEQ_W   = 6;
  localparam int DEPTH   = 16;
  localparam int AW      = $clog2(DEPTH);
  localparam int SEQ_MAX = (1 << SEQ_W) - 1;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               capture_en_i = 1'b0;
  logic [STATE_W-1:0] state_i = '0;
  logic               halt_i = 1'b0;
  logic [AW-1:0]      rd_idx_i = '0;
  logic [STATE_W-1:0] rd_state_o;
  logic [SEQ_W-1:0]   rd_seq_o;
  logic [AW-1:0]      wr_idx_o;
  logic [SEQ_W-1:0]   seq_cnt_o;
  logic               wrapped_o, halted_o;
  logic [AW:0]        entries_o;

  always #2 clk_i = ~clk_i;

  ctrl_trace_rle #(.STATE_W(STATE_W), .SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_dut (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [STATE_W+SEQ_W-1:0] exp_q[$];
  bit m_open, m_halted, m_wrapped;
  int m_start, m_last, m_seq, m_idx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_commit();
    exp_q.push_back({STATE_W'(m_start), SEQ_W'(m_seq)});
    if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
    m_idx = (m_idx + 1) % DEPTH;
    if (m_idx == 0) m_wrapped = 1;
  endtask

  task automatic model(input bit cap, input int st, input bit hlt);
    if (m_halted) return;
    if (hlt) begin
      if (m_open) m_commit();
      m_open = 0; m_halted = 1;
      return;
    end
    if (!cap) return;
    if (m_open && st == ((m_last + 1) % (1 << STATE_W)) && m_seq != SEQ_MAX) begin
      m_last = st; m_seq++;
    end else begin
      if (m_open) m_commit();
      m_open = 1; m_start = st; m_last = st; m_seq = 0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; capture_en_i = 1'b0; halt_i = 1'b0; state_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q.delete();
    m_open = 0; m_halted = 0; m_wrapped = 0;
    m_start = 0; m_last = 0; m_seq = 0; m_idx = 0;
    @(negedge clk_i);
  endtask

  // driver: one cycle of stimulus, model update, port comparison
  task automatic step(input bit cap, input int st, input bit hlt, input string req);
    capture_en_i = cap; state_i = STATE_W'(st); halt_i = hlt;
    @(posedge clk_i);
    @(negedge clk_i);
    capture_en_i = 1'b0; halt_i = 1'b0;
    model(cap, st, hlt);
    chk(wr_idx_o == AW'(m_idx), {req, " wr_idx"}, wr_idx_o, m_idx);
    if (m_open) chk(seq_cnt_o == SEQ_W'(m_seq), {req, " seq_cnt"}, seq_cnt_o, m_seq);
    chk(wrapped_o == m_wrapped, {req, " wrapped"}, wrapped_o, m_wrapped);
    chk(halted_o == m_halted, {req, " halted"}, halted_o, m_halted);
  endtask

  // monitor: drain the frozen buffer oldest first, pop and compare
  task automatic drain(input string req);
    int n;
    n = exp_q.size();
    chk(entries_o == (AW+1)'(n), {req, " R9 entries"}, entries_o, n);
    for (int i = 0; i < n; i++) begin
      logic [STATE_W+SEQ_W-1:0] e;
      e = exp_q.pop_front();
      rd_idx_i = AW'(i);
      @(posedge clk_i);
      @(negedge clk_i);
      chk(rd_state_o == e[STATE_W+SEQ_W-1:SEQ_W], {req, " R7 rd_state"},
          rd_state_o, e[STATE_W+SEQ_W-1:SEQ_W]);
      chk(rd_seq_o == e[SEQ_W-1:0], {req, " R7 rd_seq"}, rd_seq_o, e[SEQ_W-1:0]);
    end
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk(wr_idx_o == 0, "R1 wr_idx", wr_idx_o, 0);
    chk(seq_cnt_o == 0, "R1 seq_cnt", seq_cnt_o, 0);
    chk(entries_o == 0, "R1 entries", entries_o, 0);
    chk(!wrapped_o && !halted_o, "R1 flags", {wrapped_o, halted_o}, 0);

    // R2: sequential run
    step(1, 5, 0, "R2");
    step(1, 6, 0, "R2");
    step(1, 7, 0, "R2");
    step(1, 8, 0, "R2");
    chk(seq_cnt_o == 3, "R2 run length", seq_cnt_o, 3);
    // R3: held state and far jump close entries
    step(1, 8, 0, "R3");
    chk(wr_idx_o == 1, "R3 advance on hold", wr_idx_o, 1);
    step(1, 300, 0, "R3");
    // R10: modular increment
    step(1, 4095, 0, "R10");
    step(1, 0, 0, "R10");
    step(1, 1, 0, "R10");
    chk(seq_cnt_o == 2, "R10 wrap counts as sequential", seq_cnt_o, 2);
    // R5: capture disabled, junk state ignored
    step(0, 77, 0, "R5");
    step(0, 900, 0, "R5");
    step(1, 2, 0, "R5");
    chk(seq_cnt_o == 3, "R5 run continues across gap", seq_cnt_o, 3);
    // R4: saturation
    for (int i = 0; i < 70; i++) step(1, 1000 + i, 0, "R4");
    chk(seq_cnt_o == 5, "R4 new entry after saturation", seq_cnt_o, 5);
    // R6: halt flushes open entry, later input ignored
    step(0, 0, 1, "R6");
    step(1, 1070, 0, "R6");
    step(1, 5, 1, "R6");
    chk(halted_o == 1, "R6 halt sticky", halted_o, 1);
    drain("R6");

    // R8: overflow the ring with non-sequential states
    do_reset();
    for (int i = 0; i < 20; i++) step(1, 3 * i, 0, "R8");
    step(0, 0, 1, "R8");
    chk(wrapped_o == 1, "R8 wrapped", wrapped_o, 1);
    chk(wr_idx_o == 4, "R8 write index after wrap", wr_idx_o, 4);
    drain("R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule